// File: doc/BRIEF.md
# Single-wire pulse-timed bit transmitter

This host-side block turns a parallel word into a timed waveform on one wire, for a receiver that recovers each bit from pulse lengths. When a start strobe arrives while the block is idle, it captures the word. It then sends every bit, least significant first. Each bit is a high setup pulse, a short low gap, and then a data-coded high interval. A one is a long high and a short low recovery. A zero is a short high followed by a long low stretch.

After the last bit the line is parked low. It stays low until the next accepted start. All times are given in microseconds and turned into clock cycles through a clock-frequency parameter. The default gap is short enough that a receiver latching 140 µs after the setup pulse ends sees the line high for a one and low for a zero.

Top module: `pulse_bit_tx`

## Requirements
- R1: While reset is held and right after it, `line_o`, `busy_o` and `done_o` are all 0.
- R2: Every bit begins with `line_o` high for SETUP_US*CLK_MHZ cycles. The line is then low for GAP_US*CLK_MHZ cycles.
- R3: For a bit of value 1, the gap is followed by `line_o` high for ONE_HI_US*CLK_MHZ cycles. The line is then low for RECOV_US*CLK_MHZ cycles.
- R4: For a bit of value 0, the gap is followed by `line_o` high for ZERO_HI_US*CLK_MHZ cycles. The line is then low for ZERO_LO_US*CLK_MHZ cycles.
- R5: Each accepted start sends all WIDTH bits, with bit 0 first and bit WIDTH-1 last.
- R6: With the default timing, a receiver that samples the line 140 µs after the falling edge of each setup pulse sees high for a 1 and low for a 0.
- R7: A start strobe while `busy_o` is 1 is ignored. The frame in progress is neither restarted nor lengthened, and no extra word is sent.
- R8: The word is captured in the cycle the start is accepted. Changes on `data_i` during the frame do not change the bits sent.
- R9: `busy_o` rises in the cycle after the accepted start. It stays 1 until the last bit's low interval ends. `done_o` is 1 for exactly one cycle, the first cycle in which `busy_o` is 0 again.
- R10: After the last bit, `line_o` stays low for as long as the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | WIDTH | Word to send |
| start_i | input | 1 | Start request, taken only while idle |
| line_o | output | 1 | Serial line |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The bench builds the block with CLK_MHZ=1 and WIDTH=8, so that one cycle stands for one microsecond. At this setting a whole frame is about two thousand cycles, and every pulse width can be counted cycle by cycle against its requirement. A receiver model in the bench decodes each bit twice: once from the data high width, and once from the line value 140 cycles after the setup pulse falls. It rebuilds each word and compares it against the words queued at start. Starts issued mid-frame, together with changes on `data_i`, show up as a wrong busy length or a wrong word.

// File: rtl/pulse_tx_pkg.sv
package pulse_tx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_GAP,
    PH_HIGH,
    PH_LOW
  } phase_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pulse_tx_timer.sv
module pulse_tx_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R2: a running interval shortens by one cycle per clock
  a_r2_timer_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !expired_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pulse_tx_shifter.sv
module pulse_tx_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             shift_i,
  output logic             bit_o,
  output logic             last_o
);
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [WIDTH-1:0] sh_q;
  logic [IDX_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sh_q   <= data_i;
      left_q <= IDX_W'(WIDTH - 1);
    end else if (shift_i) begin
      sh_q   <= sh_q >> 1;
      left_q <= left_q - 1'b1;
    end
  end

  assign bit_o  = sh_q[0];
  assign last_o = (left_q == '0);

  // R8: captured word is untouched between capture and shifts
  a_r8_word_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(sh_q));
  // R5: never shift past the last bit
  a_r5_no_shift_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |-> !last_o);
endmodule

// File: rtl/pulse_tx_fsm.sv
module pulse_tx_fsm
  import pulse_tx_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int SETUP_C = 4,
  parameter int GAP_C   = 2,
  parameter int ONE_C   = 8,
  parameter int REC_C   = 1,
  parameter int ZH_C    = 2,
  parameter int ZL_C    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             expired_i,
  input  logic             bit_i,
  input  logic             last_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             sh_load_o,
  output logic             sh_shift_o,
  output logic             line_o,
  output logic             busy_o,
  output logic             done_o
);
  phase_e state_q, state_d;
  logic   done_q, done_d;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    sh_load_o  = 1'b0;
    sh_shift_o = 1'b0;
    done_d     = 1'b0;
    unique case (state_q)
      PH_IDLE: if (start_i) begin
        state_d    = PH_SETUP;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(SETUP_C - 1);
        sh_load_o  = 1'b1;
      end
      PH_SETUP: if (expired_i) begin
        state_d    = PH_GAP;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(GAP_C - 1);
      end
      PH_GAP: if (expired_i) begin
        state_d    = PH_HIGH;
        tmr_load_o = 1'b1;
        tmr_val_o  = bit_i ? CNT_W'(ONE_C - 1) : CNT_W'(ZH_C - 1);
      end
      PH_HIGH: if (expired_i) begin
        state_d    = PH_LOW;
        tmr_load_o = 1'b1;
        tmr_val_o  = bit_i ? CNT_W'(REC_C - 1) : CNT_W'(ZL_C - 1);
      end
      PH_LOW: if (expired_i) begin
        if (last_i) begin
          state_d = PH_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d    = PH_SETUP;
          tmr_load_o = 1'b1;
          tmr_val_o  = CNT_W'(SETUP_C - 1);
          sh_shift_o = 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign line_o = (state_q == PH_SETUP) || (state_q == PH_HIGH);
  assign busy_o = (state_q != PH_IDLE);
  assign done_o = done_q;

  // R9: done is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9: busy only drops together with done
  a_r9_busy_fall_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R10: idle line is parked low
  a_r10_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !line_o);
  // R7: a frame only starts from idle, so no reload of the word while busy
  a_r7_no_recapture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sh_load_o);
endmodule

// File: rtl/pulse_bit_tx.sv
module pulse_bit_tx
  import pulse_tx_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int CLK_MHZ    = 50,
  parameter int SETUP_US   = 60,
  parameter int GAP_US     = 20,
  parameter int ONE_HI_US  = 200,
  parameter int ZERO_HI_US = 50,
  parameter int ZERO_LO_US = 150,
  parameter int RECOV_US   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             start_i,
  output logic             line_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int SETUP_C = SETUP_US * CLK_MHZ;
  localparam int GAP_C   = GAP_US * CLK_MHZ;
  localparam int ONE_C   = ONE_HI_US * CLK_MHZ;
  localparam int ZH_C    = ZERO_HI_US * CLK_MHZ;
  localparam int ZL_C    = ZERO_LO_US * CLK_MHZ;
  localparam int REC_C   = RECOV_US * CLK_MHZ;
  localparam int MAX_C   = max2(max2(max2(SETUP_C, GAP_C), max2(ONE_C, ZH_C)),
                                max2(ZL_C, REC_C));
  localparam int CNT_W   = $clog2(MAX_C) + 1;

  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_shift, cur_bit, last_bit;

  pulse_tx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp)
  );

  pulse_tx_shifter #(.WIDTH(WIDTH)) u_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sh_load),
    .data_i  (data_i),
    .shift_i (sh_shift),
    .bit_o   (cur_bit),
    .last_o  (last_bit)
  );

  pulse_tx_fsm #(
    .CNT_W   (CNT_W),
    .SETUP_C (SETUP_C),
    .GAP_C   (GAP_C),
    .ONE_C   (ONE_C),
    .REC_C   (REC_C),
    .ZH_C    (ZH_C),
    .ZL_C    (ZL_C)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .expired_i  (tmr_exp),
    .bit_i      (cur_bit),
    .last_i     (last_bit),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .sh_load_o  (sh_load),
    .sh_shift_o (sh_shift),
    .line_o     (line_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  // R1: outputs quiet right after reset release
  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!line_o && !busy_o && !done_o));
  // R7: a start seen while busy does not end the frame early
  a_r7_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !tmr_exp) |=> busy_o);
endmodule

// File: tb/pulse_bit_tx_test.sv
`timescale 1ns/1ps
module pulse_bit_tx_test;
  localparam int W       = 8;
  localparam int SETUP_C = 60;
  localparam int GAP_C   = 20;
  localparam int ONE_C   = 200;
  localparam int ZH_C    = 50;
  localparam int ZL_C    = 150;
  localparam int REC_C   = 10;
  localparam int SAMPLE  = 140;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         start_i = 1'b0;
  logic         line_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [W-1:0] exp_q[$];

  always #10 clk = ~clk;

  pulse_bit_tx #(.WIDTH(W), .CLK_MHZ(1)) uut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .data_i  (data_i),
    .start_i (start_i),
    .line_o  (line_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // receiver model / monitor
  task automatic meas_high(output int n);
    n = 0;
    while (line_o) begin n++; @(negedge clk); end
  endtask

  task automatic meas_low(input int cap, output int n);
    n = 0;
    while (!line_o && n < cap) begin n++; @(negedge clk); end
  endtask

  initial begin
    int hs, gl, dh, dl, lo;
    bit bitv, smp;
    logic [W-1:0] word, exp_w;
    @(posedge rst_ni);
    forever begin
      word = '0;
      for (int b = 0; b < W; b++) begin
        while (!line_o) @(negedge clk);
        meas_high(hs);
        chk(hs == SETUP_C, "R2 setup high width", hs, SETUP_C);
        meas_low(1000, gl);
        chk(gl == GAP_C, "R2 gap low width", gl, GAP_C);
        meas_high(dh);
        bitv = (dh == ONE_C);
        chk(dh == ONE_C || dh == ZH_C, "R3 R4 data high width", dh, bitv ? ONE_C : ZH_C);
        smp = (gl <= SAMPLE) && (gl + dh > SAMPLE);
        chk(smp == bitv, "R6 sample point value", smp, bitv);
        lo = bitv ? REC_C : ZL_C;
        if (b < W - 1) begin
          meas_low(1000, dl);
          if (bitv) chk(dl == lo, "R3 recovery low width", dl, lo);
          else      chk(dl == lo, "R4 zero low width", dl, lo);
        end else begin
          meas_low(lo + 50, dl);
          chk(dl == lo + 50, "R10 line parked low", dl, lo + 50);
        end
        word[b] = bitv;
      end
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected extra word", int'(word), -1);
      end else begin
        exp_w = exp_q.pop_front();
        chk(word == exp_w, "R5 R8 received word", int'(word), int'(exp_w));
      end
    end
  end

  function automatic int frame_len(input logic [W-1:0] w);
    int t = 0;
    for (int i = 0; i < W; i++)
      t += SETUP_C + GAP_C + (w[i] ? (ONE_C + REC_C) : (ZH_C + ZL_C));
    return t;
  endfunction

  // driver
  task automatic send(input logic [W-1:0] w, input bit disturb);
    int n;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    data_i  = w;
    start_i = 1'b1;
    exp_q.push_back(w);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    n = 1;
    @(negedge clk);
    while (busy_o) begin
      n++;
      if (disturb && n == 300) begin
        data_i  = ~w;
        start_i = 1'b1;
      end else if (disturb && n == 301) begin
        start_i = 1'b0;
        data_i  = $urandom();
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(n == frame_len(w), "R7 R9 busy length", n, frame_len(w));
    chk(done_o == 1'b1, "R9 done with busy fall", done_o, 1);
    chk(line_o == 1'b0, "R10 line low at end", line_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done one cycle", done_o, 0);
    repeat (100) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(line_o == 1'b0, "R1 line in reset", line_o, 0);
    chk(busy_o == 1'b0, "R1 busy in reset", busy_o, 0);
    chk(done_o == 1'b0, "R1 done in reset", done_o, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk(!line_o && !busy_o && !done_o, "R1 idle after reset", line_o, 0);
    send(8'h00, 1'b0);
    send(8'hFF, 1'b0);
    send(8'hA5, 1'b1);
    send(8'h01, 1'b0);
    send(8'h80, 1'b1);
    for (int k = 0; k < 10; k++) send(W'($urandom()), k[0]);
    for (int k = 0; k < 500 && exp_q.size() != 0; k++) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all words received", exp_q.size(), 0);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule